// File: doc/BRIEF.md
# Programmable LED Event Driver

This block turns a handful of physical-layer status signals into indicator drive for a row of LEDs. Each LED output has a 4-bit source code. The management logic writes the code, and the code picks one of sixteen sources for that LED. The sources include level events (link, speed, duplex, negotiation done, far-end fault), activity events (transmit, receive, either, collision), two composites, a free-running blink, constant on and off, and a released (high-impedance) pin. Activity events are short. The block stretches each one to a minimum visible on-time. Every source code has a default that applies out of reset.

A mode input moves the three highest LED pins onto a serial link to an external shift register. In this mode the top pin carries a divided serial clock, the next pin carries a one-period latch pulse, and the third pin carries the LED data. All LED values go out once per frame. Any lower pins stay parallel. The serial clock, blink and stretch timing all come from enable counters on the single system clock.

Top module: `led_event_drv`

## Requirements
- R1: While reset is asserted and after it is released, the source codes take the DEF_SEL defaults. With the default codes (LED0 = 4, LED1 = 5, LED2 = 7, LED3 = 14) and all events low, every pin drives 0 with its enable high.
- R2: Code 0 drives the LED constantly low and code 1 drives it constantly high.
- R3: These codes follow the level events directly. Code 4 is high when the speed is 100. Code 5 is high when the link is full duplex. Code 12 is link up at 100. Code 13 is link up at 10. Code 14 is link up. Code 10 is link up with negotiation done. Code 15 is far-end fault.
- R4: The activity sources stretch their raw input. They are code 6 (collision), code 7 (transmit or receive), code 8 (transmit) and code 9 (receive). Each one reads high while its raw input is high and for STRETCH_CYC further clocks after the last clock on which the raw input was sampled high.
- R5: Code 11 is high when the link is up and the stretched code-7 activity is low.
- R6: Code 2 follows a blink signal. The blink signal is low after reset and toggles every BLINK_HALF clocks.
- R7: A write with cfg_we high loads cfg_code into the source code of the LED numbered cfg_idx. The output reflects the new code from the next clock onward, and the other LEDs keep their codes.
- R8: In parallel mode each pin is registered, so a change on an event input appears on the pin one clock after the edge that samples it.
- R9: In serial mode a frame lasts 2*(N_LED+1) half-periods of SCLK_HALF clocks each, and the serial clock is low in even half-periods. In half-periods 2k and 2k+1 the data pin carries LED k, starting with LED0. Data therefore changes only while the serial clock falls. The frame values are captured at the start of the frame.
- R10: In serial mode the last serial period of each frame raises the latch pin for exactly one serial clock period, starting on a falling edge, and the data pin is low during it.
- R11: In serial mode pin N_LED-1 is the serial clock, pin N_LED-2 is the latch and pin N_LED-3 is the data, and all three have their enable high. The lower pins stay parallel. An LED on code 3 is sent as 0.
- R12: Code 3 drops the pin's output enable and drives its value low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Source code write strobe |
| cfg_idx | input | $clog2(N_LED) | LED number to write |
| cfg_code | input | 4 | Source code to write |
| ser_mode | input | 1 | 1 selects serial output on the top three pins |
| ev_link | input | 1 | Link up |
| ev_spd100 | input | 1 | Speed is 100 (0 means 10) |
| ev_fdx | input | 1 | Full duplex |
| ev_an_done | input | 1 | Negotiation complete |
| ev_fef | input | 1 | Far-end fault |
| ev_col | input | 1 | Collision pulse |
| ev_tx | input | 1 | Transmit activity pulse |
| ev_rx | input | 1 | Receive activity pulse |
| pin_o | output | N_LED | LED pin values |
| pin_oe | output | N_LED | LED pin output enables |

## Verification
In serial mode two functions can fall in the same clock. A source-code write or an event change can land on the very edge where the serializer captures the next frame. The capture must take the pin values from before that edge, and the write shows up only in the frame after. The bench writes random codes on random LEDs in most cycles and drives random events while serial mode toggles, so writes land on frame boundaries many times. A behavioural model captures its frame from its own pre-edge LED state, and every clock its serial pins are compared with the design's.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

   typedef enum logic [3:0] {
      SRC_OFF      = 4'd0,
      SRC_ON       = 4'd1,
      SRC_BLINK    = 4'd2,
      SRC_HIZ      = 4'd3,
      SRC_SPEED    = 4'd4,
      SRC_DUPLEX   = 4'd5,
      SRC_COLL     = 4'd6,
      SRC_ACT      = 4'd7,
      SRC_TXACT    = 4'd8,
      SRC_RXACT    = 4'd9,
      SRC_LINK_AN  = 4'd10,
      SRC_LINK_ACT = 4'd11,
      SRC_LINK100  = 4'd12,
      SRC_LINK10   = 4'd13,
      SRC_LINK     = 4'd14,
      SRC_FEF      = 4'd15
   } led_src_e;

   typedef struct packed {
      logic link;
      logic spd100;
      logic fdx;
      logic an_done;
      logic fef;
      logic col_s;
      logic act_s;
      logic tx_s;
      logic rx_s;
      logic blink;
   } led_ev_t;

   // returns {release, value}
   function automatic logic [1:0] led_pick(led_src_e s, led_ev_t e);
      logic [1:0] r;
      r = 2'b00;
      case (s)
         SRC_OFF:      r = 2'b00;
         SRC_ON:       r = 2'b01;
         SRC_BLINK:    r = {1'b0, e.blink};
         SRC_HIZ:      r = 2'b10;
         SRC_SPEED:    r = {1'b0, e.spd100};
         SRC_DUPLEX:   r = {1'b0, e.fdx};
         SRC_COLL:     r = {1'b0, e.col_s};
         SRC_ACT:      r = {1'b0, e.act_s};
         SRC_TXACT:    r = {1'b0, e.tx_s};
         SRC_RXACT:    r = {1'b0, e.rx_s};
         SRC_LINK_AN:  r = {1'b0, e.link & e.an_done};
         SRC_LINK_ACT: r = {1'b0, e.link & ~e.act_s};
         SRC_LINK100:  r = {1'b0, e.link & e.spd100};
         SRC_LINK10:   r = {1'b0, e.link & ~e.spd100};
         SRC_LINK:     r = {1'b0, e.link};
         SRC_FEF:      r = {1'b0, e.fef};
         default:      r = 2'b00;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
   parameter int HOLD = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic stretched
);
   localparam int CW = $clog2(HOLD + 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("led_stretch: HOLD must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (raw)           cnt <= CW'(HOLD);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign stretched = raw | (cnt != '0);
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
   parameter int HALF = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   output logic blink
);
   localparam int CW = $clog2(HALF);

   if (HALF < 2) begin : g_bad_half
      $error("led_blink_gen: HALF must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         blink <= 1'b0;
      end else if (cnt == CW'(HALF - 1)) begin
         cnt   <= '0;
         blink <= ~blink;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/led_serializer.sv
module led_serializer #(
   parameter int N_LED     = 4,
   parameter int SCLK_HALF = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LED-1:0] led_val,
   output logic             s_clk,
   output logic             s_lat,
   output logic             s_dat
);
   localparam int POS = 2 * (N_LED + 1);
   localparam int PW  = $clog2(POS);
   localparam int IW  = $clog2(N_LED);

   if (SCLK_HALF < 1) begin : g_bad_div
      $error("led_serializer: SCLK_HALF must be at least 1");
   end

   logic             tick;
   logic [PW-1:0]    pos;
   logic [N_LED-1:0] snap;
   logic [IW-1:0]    bit_idx;

   if (SCLK_HALF == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_div
      localparam int HW = $clog2(SCLK_HALF);
      logic [HW-1:0] hcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         hcnt <= '0;
         else if (hcnt == HW'(SCLK_HALF - 1)) hcnt <= '0;
         else                                hcnt <= hcnt + 1'b1;
      end
      assign tick = (hcnt == HW'(SCLK_HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos  <= '0;
         snap <= '0;
      end else if (tick) begin
         if (pos == PW'(POS - 1)) begin
            pos  <= '0;
            snap <= led_val;
         end else begin
            pos  <= pos + 1'b1;
         end
      end
   end

   assign bit_idx = IW'(pos >> 1);
   assign s_clk   = pos[0];
   assign s_lat   = (pos >= PW'(2 * N_LED));
   assign s_dat   = ~s_lat & snap[bit_idx];
endmodule

// File: rtl/led_event_drv.sv
module led_event_drv
   import led_drv_pkg::*;
#(
   parameter int                   N_LED       = 4,
   parameter int                   SCLK_HALF   = 12,
   parameter int                   BLINK_HALF  = 2500000,
   parameter int                   STRETCH_CYC = 1250000,
   parameter logic [4*N_LED-1:0]   DEF_SEL     = (4*N_LED)'(16'hE754)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [$clog2(N_LED)-1:0]   cfg_idx,
   input  logic [3:0]                 cfg_code,
   input  logic                       ser_mode,
   input  logic                       ev_link,
   input  logic                       ev_spd100,
   input  logic                       ev_fdx,
   input  logic                       ev_an_done,
   input  logic                       ev_fef,
   input  logic                       ev_col,
   input  logic                       ev_tx,
   input  logic                       ev_rx,
   output logic [N_LED-1:0]           pin_o,
   output logic [N_LED-1:0]           pin_oe
);
   localparam int IW    = $clog2(N_LED);
   localparam int N_STR = 4;

   if (N_LED < 3) begin : g_bad_nled
      $error("led_event_drv: N_LED must be at least 3 for the serial pins");
   end

   // activity stretchers: 0 collision, 1 any activity, 2 transmit, 3 receive
   logic [N_STR-1:0] str_raw, str_out;
   assign str_raw = {ev_rx, ev_tx, ev_tx | ev_rx, ev_col};

   for (genvar k = 0; k < N_STR; k++) begin : g_str
      led_stretch #(.HOLD(STRETCH_CYC)) u_str (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (str_raw[k]),
         .stretched(str_out[k])
      );
   end

   logic blink;
   led_blink_gen #(.HALF(BLINK_HALF)) u_blink (
      .clk  (clk),
      .rst_n(rst_n),
      .blink(blink)
   );

   led_ev_t ev;
   always_comb begin
      ev.link    = ev_link;
      ev.spd100  = ev_spd100;
      ev.fdx     = ev_fdx;
      ev.an_done = ev_an_done;
      ev.fef     = ev_fef;
      ev.col_s   = str_out[0];
      ev.act_s   = str_out[1];
      ev.tx_s    = str_out[2];
      ev.rx_s    = str_out[3];
      ev.blink   = blink;
   end

   logic [N_LED-1:0] led_q, oe_q;

   for (genvar i = 0; i < N_LED; i++) begin : g_led
      led_src_e   sel_q;
      logic [1:0] pick;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  sel_q <= led_src_e'(DEF_SEL[4*i +: 4]);
         else if (cfg_we && (cfg_idx == IW'(i)))      sel_q <= led_src_e'(cfg_code);
      end

      assign pick = led_pick(sel_q, ev);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            led_q[i] <= 1'b0;
            oe_q[i]  <= 1'b1;
         end else begin
            led_q[i] <= pick[0];
            oe_q[i]  <= ~pick[1];
         end
      end
   end

   logic s_clk, s_lat, s_dat;
   led_serializer #(.N_LED(N_LED), .SCLK_HALF(SCLK_HALF)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .led_val(led_q),
      .s_clk  (s_clk),
      .s_lat  (s_lat),
      .s_dat  (s_dat)
   );

   for (genvar i = 0; i < N_LED; i++) begin : g_pin
      if (i == N_LED - 1) begin : g_sclk
         assign pin_o[i]  = ser_mode ? s_clk : led_q[i];
         assign pin_oe[i] = ser_mode | oe_q[i];
      end else if (i == N_LED - 2) begin : g_slat
         assign pin_o[i]  = ser_mode ? s_lat : led_q[i];
         assign pin_oe[i] = ser_mode | oe_q[i];
      end else if (i == N_LED - 3) begin : g_sdat
         assign pin_o[i]  = ser_mode ? s_dat : led_q[i];
         assign pin_oe[i] = ser_mode | oe_q[i];
      end else begin : g_par
         assign pin_o[i]  = led_q[i];
         assign pin_oe[i] = oe_q[i];
      end
   end
endmodule

// File: rtl/led_event_drv_chk.sv
module led_event_drv_chk #(
   parameter int N_LED     = 4,
   parameter int SCLK_HALF = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_mode,
   input logic [N_LED-1:0] pin_o,
   input logic [N_LED-1:0] pin_oe
);
   localparam int PC = N_LED - 1;
   localparam int PL = N_LED - 2;
   localparam int PD = N_LED - 3;

   // R10: data pin is low whenever the latch pin is high
   a_r10_latch_data_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && pin_o[PL]) |-> !pin_o[PD]);

   // R10: latch rises only with the serial clock low
   a_r10_latch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && $past(ser_mode) && $rose(pin_o[PL])) |-> !pin_o[PC]);

   // R9: data holds while the serial clock stays high
   a_r9_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && $past(ser_mode) && pin_o[PC] && $past(pin_o[PC]))
         |-> $stable(pin_o[PD]));

   // R11: the three serial pins are driven in serial mode
   a_r11_serial_pins_driven: assert property (@(posedge clk) disable iff (!rst_n)
      ser_mode |-> (pin_oe[PC] && pin_oe[PL] && pin_oe[PD]));

   if (SCLK_HALF >= 2) begin : g_min_high
      // R9: a serial clock high phase lasts more than one system clock
      a_r9_sclk_min_high: assert property (@(posedge clk) disable iff (!rst_n)
         (ser_mode && $past(ser_mode) && $rose(pin_o[PC])) |=> (pin_o[PC] || !ser_mode));
   end

   for (genvar i = 0; i < N_LED; i++) begin : g_hiz
      // R12: a released pin carries a low value
      a_r12_hiz_low: assert property (@(posedge clk) disable iff (!rst_n)
         !pin_oe[i] |-> !pin_o[i]);
   end
endmodule

bind led_event_drv led_event_drv_chk #(.N_LED(N_LED), .SCLK_HALF(SCLK_HALF)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ser_mode(ser_mode),
   .pin_o   (pin_o),
   .pin_oe  (pin_oe)
);

// File: tb/led_event_drv_test.sv
`timescale 1ns/100ps
module led_event_drv_test;
   localparam int N  = 4;
   localparam int SH = 3;
   localparam int BH = 20;
   localparam int ST = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_idx = '0;
   logic [3:0] cfg_code = '0;
   logic       ser_mode = 1'b0;
   logic       ev_link = 0, ev_spd100 = 0, ev_fdx = 0, ev_an_done = 0;
   logic       ev_fef = 0, ev_col = 0, ev_tx = 0, ev_rx = 0;
   logic [N-1:0] pin_o, pin_oe;

   led_event_drv #(.N_LED(N), .SCLK_HALF(SH), .BLINK_HALF(BH), .STRETCH_CYC(ST)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
      .ser_mode(ser_mode), .ev_link(ev_link), .ev_spd100(ev_spd100), .ev_fdx(ev_fdx),
      .ev_an_done(ev_an_done), .ev_fef(ev_fef), .ev_col(ev_col), .ev_tx(ev_tx),
      .ev_rx(ev_rx), .pin_o(pin_o), .pin_oe(pin_oe));

   always #2.5 clk = ~clk;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    cmp_en = 1'b0;
   string cur_req = "R1";

   // ---------------- behavioural reference model ----------------
   int      scnt[4];
   bit      blk;
   int      bcnt, hc, pos;
   bit [3:0] snap, lv, ov;
   bit [3:0] sel[4];

   function automatic bit [1:0] ref_pick(bit [3:0] s, bit [3:0] st);
      // st: 0 col, 1 act, 2 tx, 3 rx ; returns {release,value}
      case (s)
         0: return 2'b00;
         1: return 2'b01;
         2: return {1'b0, blk};
         3: return 2'b10;
         4: return {1'b0, ev_spd100};
         5: return {1'b0, ev_fdx};
         6: return {1'b0, st[0]};
         7: return {1'b0, st[1]};
         8: return {1'b0, st[2]};
         9: return {1'b0, st[3]};
         10: return {1'b0, ev_link && ev_an_done};
         11: return {1'b0, ev_link && !st[1]};
         12: return {1'b0, ev_link && ev_spd100};
         13: return {1'b0, ev_link && !ev_spd100};
         14: return {1'b0, ev_link};
         default: return {1'b0, ev_fef};
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) scnt[k] = 0;
         blk = 0; bcnt = 0; hc = 0; pos = 0; snap = 0; lv = 0; ov = 4'hF;
         sel[0] = 4; sel[1] = 5; sel[2] = 7; sel[3] = 14;
      end else begin
         bit [3:0] raw, st, nv, no;
         bit [1:0] pk;
         raw = {ev_rx, ev_tx, ev_tx | ev_rx, ev_col};
         for (int k = 0; k < 4; k++) st[k] = raw[k] || (scnt[k] > 0);
         for (int i = 0; i < N; i++) begin
            pk = ref_pick(sel[i], st);
            nv[i] = pk[0];
            no[i] = !pk[1];
         end
         if (hc == SH - 1) begin
            hc = 0;
            if (pos == 2 * N + 1) begin pos = 0; snap = lv; end
            else pos++;
         end else hc++;
         if (bcnt == BH - 1) begin bcnt = 0; blk = !blk; end else bcnt++;
         for (int k = 0; k < 4; k++) begin
            if (raw[k]) scnt[k] = ST;
            else if (scnt[k] > 0) scnt[k]--;
         end
         if (cfg_we) sel[cfg_idx] = cfg_code;
         lv = nv; ov = no;
      end
   end

   function automatic bit [7:0] exp_pins();
      bit [3:0] eo, ee;
      eo = lv; ee = ov;
      if (ser_mode) begin
         eo[3] = pos[0];
         eo[2] = (pos >= 2 * N);
         eo[1] = (pos < 2 * N) ? snap[pos / 2] : 1'b0;
         ee[3:1] = 3'b111;
      end
      return {ee, eo};
   endfunction

   always @(negedge clk) begin
      if (cmp_en) begin
         bit [7:0] e;
         e = exp_pins();
         n_checks++;
         if ({pin_oe, pin_o} !== e) begin
            n_errors++;
            $display("FAIL %s: oe/o actual=%b/%b expected=%b/%b",
                     cur_req, pin_oe, pin_o, e[7:4], e[3:0]);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wr(int idx, int code);
      cfg_we = 1; cfg_idx = 2'(idx); cfg_code = 4'(code);
      tick();
      cfg_we = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] lf;
      tick(4);
      rst_n = 1'b1;
      tick();
      cmp_en = 1'b1;
      @(negedge clk);
      check("R1 reset pins", {4'h0, pin_o}, 8'h00);
      check("R1 reset enables", {4'h0, pin_oe}, 8'h0F);
      tick(2);

      // R3 level events on default codes, R8 one-clock latency
      cur_req = "R3";
      ev_link = 1; ev_spd100 = 1; ev_fdx = 1;
      @(negedge clk);
      check("R8 not yet visible", {4'h0, pin_o}, 8'h00);
      tick();
      @(negedge clk);
      check("R3 speed/duplex/link", {4'h0, pin_o}, 8'h0B);
      tick(3);
      ev_spd100 = 0; tick(3);
      ev_fdx = 0; ev_link = 0; tick(3);

      // R2 and R12 fixed codes
      cur_req = "R2/R12";
      wr(0, 1); wr(1, 0); wr(2, 3); wr(3, 0);
      tick();
      @(negedge clk);
      check("R2 on/off", {6'h0, pin_o[1:0]}, 8'h01);
      check("R12 released", {6'h0, pin_oe[2], pin_o[2]}, 8'h00);

      // R6 blink
      cur_req = "R6";
      wr(3, 2); wr(0, 2);
      tick(70);

      // R4 activity stretch
      cur_req = "R4";
      wr(0, 8); wr(1, 9); wr(2, 6); wr(3, 7);
      ev_tx = 1; tick(); ev_tx = 0; tick(12);
      ev_rx = 1; tick(3); ev_rx = 0; tick(4);
      ev_col = 1; tick(); ev_col = 0; tick(ST);
      ev_col = 1; tick(); ev_col = 0; tick(12);

      // R5 and other composites (R3)
      cur_req = "R5";
      wr(0, 11); wr(1, 10); wr(2, 13); wr(3, 12);
      ev_link = 1; tick(3);
      ev_tx = 1; tick(); ev_tx = 0; tick(10);
      ev_an_done = 1; ev_spd100 = 1; tick(3);
      ev_spd100 = 0; tick(3);
      cur_req = "R3 fef";
      wr(2, 15); ev_fef = 1; tick(3); ev_fef = 0; tick(3);

      // R7 write takes effect from the next clock, others unchanged
      cur_req = "R7";
      wr(1, 1);
      @(negedge clk);
      check("R7 other LED kept", {7'h0, pin_o[0]}, 8'h01);
      tick();
      @(negedge clk);
      check("R7 new code seen", {7'h0, pin_o[1]}, 8'h01);

      // R9, R10, R11 serial mode
      cur_req = "R9/R10/R11";
      wr(0, 1); wr(1, 3); wr(2, 1); wr(3, 0);
      ser_mode = 1;
      tick();
      @(negedge clk);
      check("R11 serial pins driven", {5'h0, pin_oe[3:1]}, 8'h07);
      tick(3 * 2 * (N + 1) * SH);

      // random phase with coinciding writes and frame captures (R8, R9)
      cur_req = "R8/R9 random";
      lf = 32'h1234_5678;
      for (int c = 0; c < 3000; c++) begin
         lf = lf * 32'd1103515245 + 32'd12345;
         ev_link = lf[16]; ev_spd100 = lf[17]; ev_fdx = lf[18]; ev_an_done = lf[19];
         ev_fef = lf[20]; ev_col = (lf[23:21] == 0); ev_tx = (lf[26:24] == 0);
         ev_rx = (lf[29:27] == 0);
         cfg_we = lf[30]; cfg_idx = lf[10:9]; cfg_code = lf[14:11];
         if (lf[8:2] == 0) ser_mode = !ser_mode;
         tick();
      end
      cfg_we = 0;
      tick(2);
      cmp_en = 1'b0;
      finish_run();
   end
endmodule